// File: doc/BRIEF.md
# DSP Status Flags and Branch Condition Evaluator

This block holds the 16-bit status word of a small fixed-point DSP core. When an arithmetic result is presented with a valid strobe, it refreshes the arithmetic flag group from that result and from the carry and overflow information that comes with it. The result is either a wide accumulator value or a 16-bit value, chosen by a width select.

The status word has three further flags:
- a sticky overflow bit that stays set until software clears it;
- a logic-zero flag with its own write strobe;
- a multiply-mode bit that selects the product scale factor.

All remaining bits are plain read/write storage. Software can read and write the whole word through a simple write port and a read-data output.

From the registered flags, the block decodes a 4-bit branch condition code into one pass/fail signal, with no register in that path. The codes include:
- the signed compares, built from overflow XOR sign;
- zero, carry and over-32 tests;
- a composite test that passes when the result is over 32 bits or its top two bits agree, and the result is not zero.

Top module: `dsp_status_unit`

## Requirements
- R1: After reset the status word reads 0x0000, the product scale output is 2 and condition code 0x0 evaluates true.
- R2: On an update, bits 5:0 are first cleared. Then bit 0 takes the carry input, bit 2 is set when the result is zero and bit 3 is set when the result is negative. Bits 15:6 are not changed by the update, except bit 7 as given in R3.
- R3: An update with the overflow input set sets both bit 1 and bit 7. Bit 7 then stays set through later updates until a software write puts 0 in it.
- R4: For a wide update, bit 4 is set when the value differs from its low 32 bits sign-extended. Bit 5 is set when value bits 31 and 30 are equal.
- R5: For a 16-bit update, zero and sign come from value bits 15:0, bit 4 is copied from the over-32 input, and bit 5 is set when value bits 15 and 14 are equal.
- R6: The logic-zero strobe writes bit 12 with its data input. Arithmetic updates leave bit 12 unchanged.
- R7: A software write stores all 16 bits and the read data always shows the current word. When a software write meets an update or a logic-zero write in the same cycle, the update wins on the bits it writes, and the logic-zero write wins on bit 12.
- R8: With less = bit1 XOR bit3, codes 0 to 3 give not-less, less, not-less-and-not-zero, and less-or-zero. The condition output follows the registered word in the same cycle.
- R9: Codes 4 to 9 give not-zero, zero, not-carry, carry, not-over-32 and over-32.
- R10: Code 0xA is (bit4 or bit5) and not bit2, code 0xB is its inverse, 0xC is not bit12, 0xD is bit12, 0xE is bit1, and 0xF is always true.
- R11: The product scale output is 1 when bit 13 is set and 2 when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_vld | input | 1 | Result valid; refresh arithmetic flags |
| upd_wide | input | 1 | 1: wide result, 0: 16-bit result |
| upd_value | input | ACC_W | Result value (16-bit mode uses bits 15:0) |
| upd_carry | input | 1 | Carry from the result |
| upd_ovf | input | 1 | Overflow from the result |
| upd_over32 | input | 1 | Over-32 flag used in 16-bit mode |
| lz_wr | input | 1 | Logic-zero flag write strobe |
| lz_val | input | 1 | Value for the logic-zero flag |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Current status word |
| cond_code | input | 4 | Branch condition code |
| cond_true | output | 1 | Condition result |
| mul_scale | output | 2 | Product scale factor (1 or 2) |

## Verification
Every status bit is visible on the read data one cycle after the update or write that changes it. A wrong flag therefore shows on the next sample. It also shows at once on the condition output for every code that reads that flag.

A sticky bit that leaks or drops only shows up after several unrelated updates. For that reason the stimulus interleaves overflow events, software clears and ordinary updates. It checks all sixteen condition codes against the evolving word after every cycle.

// File: rtl/dsp_status_unit.sv
module dsp_status_unit #(
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_vld,
  input  logic             upd_wide,
  input  logic [ACC_W-1:0] upd_value,
  input  logic             upd_carry,
  input  logic             upd_ovf,
  input  logic             upd_over32,
  input  logic             lz_wr,
  input  logic             lz_val,
  input  logic             sw_wr,
  input  logic [15:0]      sw_wdata,
  output logic [15:0]      sw_rdata,
  input  logic [3:0]       cond_code,
  output logic             cond_true,
  output logic [1:0]       mul_scale
);
  localparam int HI_W = ACC_W - 31;
  localparam int B_C = 0, B_V = 1, B_Z = 2, B_S = 3, B_O32 = 4, B_T2 = 5;
  localparam int B_VS = 7, B_LZ = 12, B_MM = 13;

  logic [15:0] sr, sr_nxt;
  logic [5:0]  grp;
  logic [HI_W-1:0] hi;

  assign hi = upd_value[ACC_W-1:31];

  always_comb begin
    grp = '0;
    grp[B_C] = upd_carry;
    grp[B_V] = upd_ovf;
    if (upd_wide) begin
      grp[B_Z]   = (upd_value == '0);
      grp[B_S]   = upd_value[ACC_W-1];
      grp[B_O32] = ~((&hi) | ~(|hi));
      grp[B_T2]  = (upd_value[31] == upd_value[30]);
    end else begin
      grp[B_Z]   = (upd_value[15:0] == 16'h0);
      grp[B_S]   = upd_value[15];
      grp[B_O32] = upd_over32;
      grp[B_T2]  = (upd_value[15] == upd_value[14]);
    end
  end

  always_comb begin
    sr_nxt = sw_wr ? sw_wdata : sr;
    if (lz_wr) sr_nxt[B_LZ] = lz_val;
    if (upd_vld) begin
      sr_nxt[5:0] = grp;
      if (upd_ovf) sr_nxt[B_VS] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_nxt;
  end

  assign sw_rdata  = sr;
  assign mul_scale = sr[B_MM] ? 2'd1 : 2'd2;

  logic less, zf, cond_a;
  assign less   = sr[B_V] ^ sr[B_S];
  assign zf     = sr[B_Z];
  assign cond_a = (sr[B_O32] | sr[B_T2]) & ~zf;

  always_comb begin
    case (cond_code)
      4'h0: cond_true = ~less;
      4'h1: cond_true = less;
      4'h2: cond_true = ~less & ~zf;
      4'h3: cond_true = less | zf;
      4'h4: cond_true = ~zf;
      4'h5: cond_true = zf;
      4'h6: cond_true = ~sr[B_C];
      4'h7: cond_true = sr[B_C];
      4'h8: cond_true = ~sr[B_O32];
      4'h9: cond_true = sr[B_O32];
      4'hA: cond_true = cond_a;
      4'hB: cond_true = ~cond_a;
      4'hC: cond_true = ~sr[B_LZ];
      4'hD: cond_true = sr[B_LZ];
      4'hE: cond_true = sr[B_V];
      default: cond_true = 1'b1;
    endcase
  end

  p_carry_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |=> sr[B_C] == $past(upd_carry));
  p_ovf_sets_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld && upd_ovf |=> sr[B_V] && sr[B_VS]);
  p_sticky_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sr[B_VS] && !sw_wr |=> sr[B_VS]);
  p_narrow_o32_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld && !upd_wide |=> sr[B_O32] == $past(upd_over32));
  p_lz_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld && !lz_wr && !sw_wr |=> $stable(sr[B_LZ]));
  p_lz_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lz_wr |=> sr[B_LZ] == $past(lz_val));
  p_always_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cond_code == 4'hF |-> cond_true);
  p_scale_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mul_scale) == 1);
endmodule

// File: tb/dsp_status_unit_tb_top.sv
`timescale 1ns/1ps
module dsp_status_unit_tb_top;
  localparam int ACC_W = 40;
  logic clk = 0, rst_n = 0;
  logic upd_vld = 0, upd_wide = 0, upd_carry = 0, upd_ovf = 0, upd_over32 = 0;
  logic [ACC_W-1:0] upd_value = '0;
  logic lz_wr = 0, lz_val = 0, sw_wr = 0;
  logic [15:0] sw_wdata = '0, sw_rdata;
  logic [3:0] cond_code = '0;
  logic cond_true;
  logic [1:0] mul_scale;
  int nchk = 0, nfail = 0, cyc = 0;
  logic [15:0] m;

  always #4 clk = ~clk;

  dsp_status_unit #(.ACC_W(ACC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .upd_vld(upd_vld), .upd_wide(upd_wide),
    .upd_value(upd_value), .upd_carry(upd_carry), .upd_ovf(upd_ovf),
    .upd_over32(upd_over32), .lz_wr(lz_wr), .lz_val(lz_val), .sw_wr(sw_wr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .cond_code(cond_code),
    .cond_true(cond_true), .mul_scale(mul_scale));

  function automatic logic [15:0] model_next(logic [15:0] s);
    logic [15:0] b;
    logic [ACC_W-1:0] sx;
    b = sw_wr ? sw_wdata : s;
    if (lz_wr) b[12] = lz_val;
    if (upd_vld) begin
      b[5:0] = '0;
      b[0] = upd_carry;
      b[1] = upd_ovf;
      if (upd_ovf) b[7] = 1'b1;
      if (upd_wide) begin
        sx = {{(ACC_W-32){upd_value[31]}}, upd_value[31:0]};
        b[2] = (upd_value == 0);
        b[3] = upd_value[ACC_W-1];
        b[4] = (sx != upd_value);
        b[5] = (upd_value[31] == upd_value[30]);
      end else begin
        b[2] = (upd_value[15:0] == 0);
        b[3] = upd_value[15];
        b[4] = upd_over32;
        b[5] = (upd_value[15] == upd_value[14]);
      end
    end
    return b;
  endfunction

  function automatic logic model_cond(logic [15:0] s, logic [3:0] c);
    logic l, a;
    l = s[1] ^ s[3];
    a = (s[4] | s[5]) & ~s[2];
    case (c)
      0: return ~l;            1: return l;
      2: return ~l & ~s[2];    3: return l | s[2];
      4: return ~s[2];         5: return s[2];
      6: return ~s[0];         7: return s[0];
      8: return ~s[4];         9: return s[4];
      10: return a;            11: return ~a;
      12: return ~s[12];       13: return s[12];
      14: return s[1];         default: return 1'b1;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    upd_vld = 0; lz_wr = 0; sw_wr = 0;
  endtask

  task automatic step();
    logic [15:0] nx;
    nx = model_next(m);
    @(posedge clk); @(negedge clk);
    m = nx;
    check("R7 word", sw_rdata, m);
    check("R11 scale", {14'h0, mul_scale}, m[13] ? 16'd1 : 16'd2);
    for (int c = 0; c < 16; c++) begin
      cond_code = c[3:0]; #1;
      check(c < 4 ? "R8 cond" : (c < 10 ? "R9 cond" : "R10 cond"),
            {15'h0, cond_true}, {15'h0, model_cond(m, c[3:0])});
    end
    idle();
  endtask

  task automatic upd(logic w, logic [ACC_W-1:0] v, logic c, logic o, logic o32);
    upd_vld = 1; upd_wide = w; upd_value = v; upd_carry = c; upd_ovf = o; upd_over32 = o32;
  endtask

  initial begin
    @(posedge clk);
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        nchk++; nfail++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    check("R1 reset word", sw_rdata, 16'h0000);
    check("R1 reset scale", {14'h0, mul_scale}, 16'd2);
    cond_code = 0; #1;
    check("R1 reset GE", {15'h0, cond_true}, 16'h1);

    sw_wr = 1; sw_wdata = 16'hFFFF; step();              // R7 all bits stored
    check("R2 upper kept", {sw_rdata[15:8], sw_rdata[6]}, 9'h1FF);
    upd(1, 40'h00_0000_0000, 0, 0, 0); step();          // R2 zero, R4 top2
    check("R2 clear group", {10'h0, sw_rdata[5:0]}, 16'h0024);
    check("R6 lz kept", {15'h0, sw_rdata[12]}, 16'h1);
    sw_wr = 1; sw_wdata = 16'h0000; step();              // R3 sticky cleared by write
    check("R3 sticky clear", {15'h0, sw_rdata[7]}, 16'h0);
    upd(1, 40'h00_8000_0000, 1, 1, 0); step();          // R4 over32
    check("R4 over32 wide", {15'h0, sw_rdata[4]}, 16'h1);
    check("R3 ovf both", {14'h0, sw_rdata[7], sw_rdata[1]}, 16'h3);
    upd(0, 40'hFF_FFFF_4000, 0, 0, 1); step();          // R5 narrow
    check("R5 narrow", {10'h0, sw_rdata[5:0]}, 16'h0010);
    check("R3 sticky held", {15'h0, sw_rdata[7]}, 16'h1);
    upd(0, 40'h00_0000_C001, 0, 0, 0); step();
    check("R5 narrow sign top2", {10'h0, sw_rdata[5:0]}, 16'h0028);
    sw_wr = 1; sw_wdata = 16'h0000; upd(1, 40'h00_0000_0001, 1, 1, 0);
    lz_wr = 1; lz_val = 1; step();                       // R7 collision
    check("R7 update wins", sw_rdata, 16'h10A3);
    sw_wr = 1; sw_wdata = 16'h2000; lz_wr = 1; lz_val = 1; step();
    check("R6 lz wins over write", sw_rdata, 16'h3000);
    check("R11 scale one", {14'h0, mul_scale}, 16'd1);
    upd(1, 40'hFF_FFFF_FFFF, 0, 0, 0); step();          // R4 negative small
    check("R4 neg no over32", {10'h0, sw_rdata[5:0]}, 16'h0028);

    for (int i = 0; i < 3000; i++) begin
      logic [ACC_W-1:0] v;
      case ($urandom % 4)
        0: v = '0;
        1: v = {{(ACC_W-32){1'b0}}, 32'($urandom)};
        2: v = {{(ACC_W-16){1'b1}}, 16'($urandom)};
        default: v = {8'($urandom), 32'($urandom)};
      endcase
      upd_vld = ($urandom % 3) != 0;
      upd_wide = $urandom % 2; upd_value = v;
      upd_carry = $urandom % 2; upd_ovf = ($urandom % 4) == 0;
      upd_over32 = $urandom % 2;
      lz_wr = ($urandom % 4) == 0; lz_val = $urandom % 2;
      sw_wr = ($urandom % 8) == 0; sw_wdata = 16'($urandom);
      step();                                            // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule